// File: doc/BRIEF.md
# Read Latency and Byte-Mask Pipeline

This block is the data-path timing stage of a synchronous DRAM device model. The array side hands it one internal word per read strobe. The block holds each word for a run-time selected CAS latency of two or three clocks. It then drives the word onto a 32-bit output bus, with a registered per-byte output enable, so that high-impedance cycles can be seen directly as enable-low lanes.

Per-byte mask inputs are sampled on every clock edge. A mask bit raised during a read blanks its lane on the word that appears two clocks later. A mask bit raised during a write withholds that lane's write strobe in the same cycle.

A clock-enable input suspends the whole pipeline one cycle after it is sampled low. A stop input, standing for a precharge or burst stop, ends the current read burst. The bus then releases after a number of cycles equal to the latency.

Top module: `rdlat_top`

## Requirements
- R1: A read word accepted at posedge n with `cas_lat3`=0 is loaded onto `dq_out`/`dq_oe` at posedge n+1, so it is valid by posedge n+2.
- R2: A read word accepted at posedge n with `cas_lat3`=1 is loaded at posedge n+2, so it is valid by posedge n+3.
- R3: Each word drives the bus for exactly one cycle. `dq_oe` is 0 in the cycle before it and is 0 again after it unless another word follows. A lane whose `dq_oe` bit is 0 reads as zero on `dq_out`.
- R4: `dqm` sampled at posedge m controls the word loaded at posedge m+1, so a read mask acts two clocks after it is sampled. A set bit clears that lane's `dq_oe` bit and zeroes its data.
- R5: Lane i of both masks and both enables covers data bits 8i+7 down to 8i. Bit 3 covers bits 31..24 and bit 0 covers bits 7..0.
- R6: A write mask has zero latency. `wr_strobe[i]` = `wr_req` AND NOT `dqm[i]`, combinationally in the same cycle, while the clock is not suspended.
- R7: If `cke` is sampled low at posedge k, every posedge from k+1 on is frozen: outputs, stored words and the sampled mask hold, and read inputs are ignored. `wr_strobe` is 0 from just after edge k. This lasts until `cke` is sampled high at some posedge j; posedge j+1 runs normally.
- R8: `rd_stop` sampled at posedge s discards the word strobed at s. It also discards every later word until a strobe with `rd_start`=1. The bus is therefore released (`dq_oe`=0) from posedge s+L-1, where L is the latency.
- R9: Each word keeps the latency selected at its own accept edge. A latency change does not alter words already in flight.
- R10: If an older latency-3 word and a newer latency-2 word are due at the same edge, the older word is driven and the newer word is dropped.
- R11: While `rst_n` is low, `dq_oe` and `dq_out` are zero and the pipeline is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low suspends from the next cycle |
| cas_lat3 | input | 1 | Latency select: 0 = two clocks, 1 = three clocks |
| rd_start | input | 1 | Marks the first word of a new read burst |
| rd_valid | input | 1 | Read word strobe from the array |
| rd_stop | input | 1 | Precharge or burst stop during a read |
| rd_data | input | 32 | Read word from the array |
| dqm | input | 4 | Per-byte mask, one bit per lane |
| wr_req | input | 1 | Write data cycle in progress |
| wr_strobe | output | 4 | Per-lane write accept |
| dq_out | output | 32 | Output data bus |
| dq_oe | output | 4 | Registered per-lane output enable |

## Verification
The bound checker watches several rules on every cycle. It checks that outputs hold through a suspended edge. It checks that write strobes never coincide with a set mask bit. It checks that disabled lanes read zero, and that a read mask sampled two edges earlier blanks its lane. It also checks that a latency-3 word arrives three edges after it is accepted when the clock runs. Only the bench's scenarios can show the rest: the exact first-drive cycle for each latency, the release timing after a stop and the restart on a new burst, words in flight across a latency change, the collision rule, and that reads presented while suspended never appear.

// File: rtl/rdlat_pkg.sv
package rdlat_pkg;

  localparam int unsigned LANE_BITS = 8;

  typedef enum logic {
    CL_TWO   = 1'b0,
    CL_THREE = 1'b1
  } cas_lat_e;

  // Number of running edges between the accept edge and the edge that
  // loads the word into the output register (latency minus one).
  function automatic int unsigned load_delay(cas_lat_e cl);
    return (cl == CL_THREE) ? 2 : 1;
  endfunction

endpackage

// File: rtl/rdlat_stage_pipe.sv
module rdlat_stage_pipe
  import rdlat_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              acc,
  input  cas_lat_e          acc_cl,
  input  logic [DATA_W-1:0] acc_data,
  output logic              nxt_vld,
  output logic [DATA_W-1:0] nxt_data
);

  logic              s0_vld;
  cas_lat_e          s0_cl;
  logic [DATA_W-1:0] s0_data;
  logic              s1_vld;
  logic [DATA_W-1:0] s1_data;
  logic              s0_direct;

  // A stage-0 word with a one-edge load delay goes straight to the output.
  assign s0_direct = s0_vld && (load_delay(s0_cl) == 1);

  // The older word in stage 1 has priority over a direct stage-0 word.
  always_comb begin
    nxt_vld  = s1_vld || s0_direct;
    nxt_data = s1_vld ? s1_data : s0_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_vld  <= 1'b0;
      s0_cl   <= CL_TWO;
      s0_data <= '0;
      s1_vld  <= 1'b0;
      s1_data <= '0;
    end else if (run) begin
      s0_vld  <= acc;
      s0_cl   <= acc_cl;
      s0_data <= acc_data;
      s1_vld  <= s0_vld && !s0_direct;
      s1_data <= s0_data;
    end
  end

endmodule

// File: rtl/rdlat_out_reg.sv
module rdlat_out_reg #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [LANES-1:0]  dqm,
  input  logic              nxt_vld,
  input  logic [DATA_W-1:0] nxt_data,
  output logic              out_vld,
  output logic [DATA_W-1:0] dq_out,
  output logic [LANES-1:0]  dq_oe
);

  logic [LANES-1:0] dqm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dqm_q   <= '0;
      out_vld <= 1'b0;
    end else if (run) begin
      dqm_q   <= dqm;
      out_vld <= nxt_vld;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic              lane_on;
    logic              lane_oe;
    logic [LANE_W-1:0] lane_q;

    assign lane_on = nxt_vld && !dqm_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_oe <= 1'b0;
        lane_q  <= '0;
      end else if (run) begin
        lane_oe <= lane_on;
        lane_q  <= lane_on ? nxt_data[i*LANE_W +: LANE_W] : '0;
      end
    end

    assign dq_oe[i]                   = lane_oe;
    assign dq_out[i*LANE_W +: LANE_W] = lane_q;
  end

endmodule

// File: rtl/rdlat_wr_gate.sv
module rdlat_wr_gate #(
  parameter int unsigned LANES = 4
) (
  input  logic             run,
  input  logic             wr_req,
  input  logic [LANES-1:0] dqm,
  output logic [LANES-1:0] wr_strobe
);

  assign wr_strobe = {LANES{wr_req && run}} & ~dqm;

endmodule

// File: rtl/rdlat_top.sv
module rdlat_top
  import rdlat_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = LANE_BITS,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cas_lat3,
  input  logic              rd_start,
  input  logic              rd_valid,
  input  logic              rd_stop,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [LANES-1:0]  dqm,
  input  logic              wr_req,
  output logic [LANES-1:0]  wr_strobe,
  output logic [DATA_W-1:0] dq_out,
  output logic [LANES-1:0]  dq_oe
);

  logic              cke_q;
  logic              run;
  logic              halted;
  logic              rd_accept;
  logic              rd_accept_l2;
  logic              rd_accept_l3;
  logic              nxt_vld;
  logic [DATA_W-1:0] nxt_data;
  logic              out_word_vld;
  cas_lat_e          acc_cl;

  // The clock enable sampled at one edge gates the following edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke;
  end

  assign run = cke_q;

  // Burst halt: set by a stop, cleared by the first word of a new burst.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        halted <= 1'b0;
    else if (run) begin
      if (rd_stop)       halted <= 1'b1;
      else if (rd_start) halted <= 1'b0;
    end
  end

  assign acc_cl       = cas_lat3 ? CL_THREE : CL_TWO;
  assign rd_accept    = run && rd_valid && !rd_stop && (rd_start || !halted);
  assign rd_accept_l2 = rd_accept && (acc_cl == CL_TWO);
  assign rd_accept_l3 = rd_accept && (acc_cl == CL_THREE);

  rdlat_stage_pipe #(.DATA_W(DATA_W)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .acc      (rd_accept),
    .acc_cl   (acc_cl),
    .acc_data (rd_data),
    .nxt_vld  (nxt_vld),
    .nxt_data (nxt_data)
  );

  rdlat_out_reg #(.LANES(LANES), .LANE_W(LANE_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .dqm      (dqm),
    .nxt_vld  (nxt_vld),
    .nxt_data (nxt_data),
    .out_vld  (out_word_vld),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
  );

  rdlat_wr_gate #(.LANES(LANES)) u_wr (
    .run       (run),
    .wr_req    (wr_req),
    .dqm       (dqm),
    .wr_strobe (wr_strobe)
  );

endmodule

// File: rtl/rdlat_top_chk.sv
module rdlat_top_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic [LANES-1:0]  dqm,
  input logic [LANES-1:0]  wr_strobe,
  input logic [DATA_W-1:0] dq_out,
  input logic [LANES-1:0]  dq_oe,
  input logic              rd_accept_l3,
  input logic              out_word_vld
);

  // R7: an edge that follows a low clock enable changes no output
  assert_frozen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> ##1 ($stable(dq_oe) && $stable(dq_out)));

  // R6: a write strobe never coincides with its mask bit
  assert_wr_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe & dqm) == '0);

  // R4: a mask sampled two edges back blanks its lane
  assert_rd_mask_lat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cke, 2) && $past(cke, 3)) |-> ((dq_oe & $past(dqm, 2)) == '0));

  // R2: a latency-3 word is on the bus three edges after accept
  assert_cl3_delivery_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_accept_l3, 3) && $past(cke, 3) && $past(cke, 2)) |-> out_word_vld);

  for (genvar i = 0; i < LANES; i++) begin : g_idle
    // R3: a lane that is not enabled reads zero
    assert_idle_lane_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe[i] |-> (dq_out[i*LANE_W +: LANE_W] == '0));
  end

endmodule

bind rdlat_top rdlat_top_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cke          (cke),
  .dqm          (dqm),
  .wr_strobe    (wr_strobe),
  .dq_out       (dq_out),
  .dq_oe        (dq_oe),
  .rd_accept_l3 (rd_accept_l3),
  .out_word_vld (out_word_vld)
);

// File: tb/rdlat_top_bench.sv
`timescale 1ns/1ps
module rdlat_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1;
  logic        cas_lat3 = 1'b0;
  logic        rd_start = 1'b0;
  logic        rd_valid = 1'b0;
  logic        rd_stop = 1'b0;
  logic [31:0] rd_data = '0;
  logic [3:0]  dqm = '0;
  logic        wr_req = 1'b0;
  logic [3:0]  wr_strobe;
  logic [31:0] dq_out;
  logic [3:0]  dq_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rdlat_top u_rdlat_top (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cas_lat3(cas_lat3),
    .rd_start(rd_start), .rd_valid(rd_valid), .rd_stop(rd_stop),
    .rd_data(rd_data), .dqm(dqm), .wr_req(wr_req),
    .wr_strobe(wr_strobe), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  // {latency-3 select, read mask, word}
  localparam logic [36:0] VEC [6] = '{
    {1'b0, 4'b0000, 32'hA1B2_C3D4},
    {1'b1, 4'b0000, 32'h5566_7788},
    {1'b0, 4'b1000, 32'hDEAD_BEEF},
    {1'b1, 4'b0001, 32'hCAFE_F00D},
    {1'b0, 4'b0101, 32'h0123_4567},
    {1'b1, 4'b1110, 32'h89AB_CDEF}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] masked(input logic [31:0] d, input logic [3:0] m);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = m[i] ? 8'h00 : d[i*8 +: 8];
    return r;
  endfunction

  task automatic put_read(input logic st, input logic l3, input logic [31:0] d);
    rd_start = st; rd_valid = 1'b1; cas_lat3 = l3; rd_data = d;
  endtask

  task automatic idle_read();
    rd_start = 1'b0; rd_valid = 1'b0; rd_stop = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    chk("R11 reset oe", {60'b0, dq_oe}, 64'h0);
    chk("R11 reset data", {32'b0, dq_out}, 64'h0);
    rst_n = 1'b1;
    tick();

    // R1 R2 R3 R4 R5: table walk
    for (int v = 0; v < 6; v++) begin
      logic        l3;
      logic [3:0]  m;
      logic [31:0] d;
      {l3, m, d} = VEC[v];
      put_read(1'b1, l3, d);
      dqm = l3 ? 4'b0000 : m;
      tick();                                 // accept edge n
      idle_read();
      if (l3) begin
        dqm = m;
        chk("R3 no drive before first edge", {60'b0, dq_oe}, 64'h0);
        tick();                               // edge n+1
        chk("R2 not yet at n+1", {60'b0, dq_oe}, 64'h0);
      end
      dqm = 4'b0000;
      tick();                                 // edge n+L-1
      chk(l3 ? "R2 R4 R5 oe" : "R1 R4 R5 oe", {60'b0, dq_oe}, {60'b0, ~m});
      chk(l3 ? "R2 R4 R5 data" : "R1 R4 R5 data", {32'b0, dq_out}, {32'b0, masked(d, m)});
      tick();
      chk("R3 released after word", {60'b0, dq_oe}, 64'h0);
      chk("R3 idle data zero", {32'b0, dq_out}, 64'h0);
    end

    // R6: write masks act in the same cycle
    wr_req = 1'b1; dqm = 4'b0110; #1;
    chk("R6 write strobe masked", {60'b0, wr_strobe}, 64'h9);
    dqm = 4'b0000; #1;
    chk("R6 write strobe open", {60'b0, wr_strobe}, 64'hF);
    wr_req = 1'b0; tick();

    // R9: latency 2 word then latency 3 word
    put_read(1'b1, 1'b0, 32'h1111_1111); tick();
    put_read(1'b0, 1'b1, 32'h2222_2222); tick();
    idle_read();
    chk("R9 first word at n+1", {32'b0, dq_out}, 64'h1111_1111);
    tick();
    chk("R9 gap at n+2", {60'b0, dq_oe}, 64'h0);
    tick();
    chk("R9 second word keeps latency 3", {32'b0, dq_out}, 64'h2222_2222);
    tick(); tick();

    // R10: latency 3 word then latency 2 word collide
    put_read(1'b1, 1'b1, 32'h3333_3333); tick();
    put_read(1'b0, 1'b0, 32'h4444_4444); tick();
    idle_read();
    chk("R10 nothing at n+1", {60'b0, dq_oe}, 64'h0);
    tick();
    chk("R10 older word wins", {32'b0, dq_out}, 64'h3333_3333);
    tick();
    chk("R10 newer word dropped", {60'b0, dq_oe}, 64'h0);
    tick();

    // R8: stop during a latency 3 burst
    put_read(1'b1, 1'b1, 32'h5555_AAAA); tick();       // edge n
    put_read(1'b0, 1'b1, 32'h6666_BBBB); rd_stop = 1'b1; tick();  // edge s=n+1
    rd_stop = 1'b0; put_read(1'b0, 1'b1, 32'h7777_CCCC); tick();  // edge n+2
    idle_read();
    chk("R8 word before stop driven", {32'b0, dq_out}, 64'h5555_AAAA);
    tick();
    chk("R8 released at s+L-1", {60'b0, dq_oe}, 64'h0);
    tick();
    chk("R8 later word discarded", {60'b0, dq_oe}, 64'h0);
    put_read(1'b1, 1'b0, 32'h8888_DDDD); tick();
    idle_read(); tick();
    chk("R8 new burst restarts", {32'b0, dq_out}, 64'h8888_DDDD);
    tick();

    // R7: suspension freezes the bus and ignores inputs
    put_read(1'b1, 1'b0, 32'h9999_EEEE); tick();       // edge n
    idle_read(); cke = 1'b0; tick();                   // edge n+1 runs
    chk("R7 word loaded before freeze", {32'b0, dq_out}, 64'h9999_EEEE);
    wr_req = 1'b1; #1;
    chk("R7 write blocked while suspended", {60'b0, wr_strobe}, 64'h0);
    put_read(1'b1, 1'b0, 32'hBAD0_BAD0);
    tick();                                            // edge n+2 frozen
    chk("R7 held at n+2", {32'b0, dq_out}, 64'h9999_EEEE);
    cke = 1'b1; tick();                                // edge n+3 frozen
    chk("R7 held at n+3", {60'b0, dq_oe}, 64'hF);
    idle_read(); wr_req = 1'b0; tick();                // edge n+4 runs
    chk("R7 resumes and read during freeze ignored", {60'b0, dq_oe}, 64'h0);
    tick();
    chk("R7 ignored word never appears", {60'b0, dq_oe}, 64'h0);

    // R11: reset mid-read clears the bus
    put_read(1'b1, 1'b0, 32'hFFFF_0000); tick(); idle_read(); tick();
    rst_n = 1'b0; #1;
    chk("R11 reset clears driven word", {60'b0, dq_oe}, 64'h0);
    tick(); rst_n = 1'b1; tick();
    chk("R11 empty after reset", {32'b0, dq_out}, 64'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule